// File: doc/BRIEF.md
# I2C Slave Transmitter with Empty/End Handshake

This block is an I2C-bus slave that serves master reads. While it is enabled it listens in receive mode for a START condition. It then compares the first byte of the frame against a 7-bit own address. On a match it answers on the ninth clock with an acknowledge level that the host programs. If the direction bit asks for a read, the block switches itself into transmit mode without any host action.

In transmit mode the host feeds bytes through a single-entry transmit buffer, and an empty flag paces those writes. Each byte is copied into a shifter and sent most significant bit first. The empty flag rises again as soon as the buffer has been copied, so the host can queue the next byte while the current one is still on the wire. An end flag marks a byte that finished while no further byte was waiting. When no data is available after an acknowledged byte, the slave stretches the clock. It lets SCL go only after the host has cleared transmit mode and then done a dummy read of the receive register. If the master does not acknowledge a byte, the slave drops off the bus and waits for a STOP or a new START.

Both bus lines are open-drain. The block never drives a high level. It only asserts a pull-low enable for each line.

Top module: `i2c_slave_tx`

## Requirements
- R1: Out of reset, both pull-low enables are 0 and the flags `xmit_mode`, `tx_empty` and `tx_done` are all 0.
- R2: The address is compared only in the first byte after a START, a falling SDA edge while SCL is high. Bits 7..1 of that byte are the address. A byte that does not match, or bits clocked with no START before them, gives no acknowledge and leaves every flag unchanged.
- R3: On an address match, the slave applies the level of `ack_val` to SDA for the whole of the ninth clock. With `ack_val`=0 it pulls SDA low. With `ack_val`=1 it leaves SDA released.
- R4: Bit 0 of the address byte is the direction bit, and 1 means read. On a match with that bit at 1, `xmit_mode` and `tx_empty` rise together at the ninth rising SCL edge. With that bit at 0, `xmit_mode` stays 0. In both cases `rx_data` holds the whole address byte afterwards.
- R5: Data bytes leave on SDA most significant bit first, and the slave changes its SDA drive only while SCL is low.
- R6: A `tx_wr` pulse stores `tx_data` and clears `tx_empty`. When the byte is copied into the shifter, `tx_empty` is set again. A byte written before the master's acknowledge is sent next with no clock stretch.
- R7: `tx_done` is set at the ninth rising SCL edge of a data byte if `tx_empty` is 1 at that moment. A `done_clr` pulse clears it.
- R8: After an acknowledged byte, the slave holds SCL low for as long as `tx_empty` is 1.
- R9: A held SCL is released only by an `rx_rd` pulse given while `xmit_mode` is 0. A `xmit_clr` pulse on its own keeps SCL held. `tx_empty` stays 1 after the release until an `empty_clr` pulse clears it.
- R10: If the master answers a data byte with a not-acknowledge (SDA high), the slave releases SDA, does not hold SCL, and ignores the bus until the next STOP or START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enables the controller; 0 forces it idle and clears the flags |
| own_addr | input | 7 | Own 7-bit slave address |
| ack_val | input | 1 | Level driven in the address acknowledge slot (0 = acknowledge) |
| scl_i | input | 1 | Sensed SCL line |
| sda_i | input | 1 | Sensed SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| tx_wr | input | 1 | One-cycle strobe writing `tx_data` into the transmit buffer |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | One-cycle strobe: read of the receive register (dummy read) |
| rx_data | output | 8 | Last received address byte |
| xmit_clr | input | 1 | One-cycle strobe clearing `xmit_mode` |
| done_clr | input | 1 | One-cycle strobe clearing `tx_done` |
| empty_clr | input | 1 | One-cycle strobe clearing `tx_empty` |
| xmit_mode | output | 1 | Transmit-mode flag |
| tx_empty | output | 1 | Transmit buffer empty flag |
| tx_done | output | 1 | Transmission end flag |

## Verification
The assertions check several rules on every cycle. SDA drive changes only while the synchronized SCL is low. The acknowledge slot carries the programmed level. Transmit mode never rises without the empty flag, and neither does the end flag. Any release of a held SCL follows a buffer write or a dummy read made outside transmit mode. Some behaviour can only be shown by the bench's scenarios, which run an open-drain master model against the block. These are the byte contents and their order on the wire, the pacing of a two-byte burst with no stretch between the bytes, and the exact point at which the stretch is released. The scenarios also show that mismatched or START-less address bytes are ignored and that the slave drops off the bus after a not-acknowledge.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_LOAD,
    ST_SHIFT,
    ST_MACK,
    ST_WSTOP
  } stx_state_e;

  // Address compare: upper bits of the first frame against own address.
  function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] own);
    return frame[7:1] == own;
  endfunction

  // Pull-low enable for a wanted SDA level (open drain).
  function automatic logic pull_for(input logic level);
    return ~level;
  endfunction

  // Direction bit of the address frame, 1 = master reads.
  function automatic logic is_read(input logic [7:0] frame);
    return frame[0];
  endfunction

endpackage

// File: rtl/i2c_stx_sync.sv
module i2c_stx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_stx_flags.sv
module i2c_stx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set_xmit,
  input  logic clr_xmit_bus,
  input  logic clr_xmit_host,
  input  logic set_empty,
  input  logic clr_empty_wr,
  input  logic clr_empty_host,
  input  logic set_done,
  input  logic clr_done_bus,
  input  logic clr_done_host,
  output logic xmit_mode,
  output logic tx_empty,
  output logic tx_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xmit_mode <= 1'b0;
      tx_empty  <= 1'b0;
      tx_done   <= 1'b0;
    end else if (!en) begin
      xmit_mode <= 1'b0;
      tx_empty  <= 1'b0;
      tx_done   <= 1'b0;
    end else begin
      if (set_xmit)                          xmit_mode <= 1'b1;
      else if (clr_xmit_bus || clr_xmit_host) xmit_mode <= 1'b0;
      // A host write wins over a load so no byte is silently lost.
      if (clr_empty_wr || clr_empty_host)    tx_empty <= 1'b0;
      else if (set_empty)                    tx_empty <= 1'b1;
      if (set_done)                          tx_done <= 1'b1;
      else if (clr_done_bus || clr_done_host) tx_done <= 1'b0;
    end
  end

  // R7: the end flag only ever rises together with an empty buffer
  assert_done_needs_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> tx_empty);

endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
  import i2c_stx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_val,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  input  logic              xmit_clr,
  input  logic              done_clr,
  input  logic              empty_clr,
  output logic              xmit_mode,
  output logic              tx_empty,
  output logic              tx_done
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  stx_state_e state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg, tx_buf, rx_q;
  logic rw_q, ackv_q, nack_q, sda_oe_r;

  // Named internal events, shared by the FSM, the flags and the assertions
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic live, ev_read_hit, ev_write_hit, ev_load, ev_done, ev_release;

  i2c_stx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign live         = en & ~start_evt & ~stop_evt;
  assign ev_read_hit  = live & (state == ST_AACK) & scl_rise & rw_q;
  assign ev_write_hit = live & (state == ST_AACK) & scl_rise & ~rw_q;
  assign ev_load      = live & (state == ST_LOAD) & ~tx_empty;
  assign ev_done      = live & (state == ST_MACK) & scl_rise & tx_empty;
  assign ev_release   = live & (state == ST_LOAD) & tx_empty & ~xmit_mode & rx_rd;

  i2c_stx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .en(en),
    .set_xmit(ev_read_hit), .clr_xmit_bus(ev_write_hit), .clr_xmit_host(xmit_clr),
    .set_empty(ev_read_hit | ev_load), .clr_empty_wr(tx_wr), .clr_empty_host(empty_clr),
    .set_done(ev_done), .clr_done_bus(ev_read_hit), .clr_done_host(done_clr),
    .xmit_mode(xmit_mode), .tx_empty(tx_empty), .tx_done(tx_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_buf <= '0;
    else if (tx_wr) tx_buf <= tx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      rx_q     <= '0;
      rw_q     <= 1'b0;
      ackv_q   <= 1'b1;
      nack_q   <= 1'b0;
      sda_oe_r <= 1'b0;
    end else if (!en) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      sda_oe_r <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      sda_oe_r <= 1'b0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      sda_oe_r <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg   <= {shreg[DATA_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == LAST_BIT) begin
            rx_q <= shreg;
            if (addr_hit(shreg, own_addr)) begin
              state    <= ST_AACK;
              rw_q     <= is_read(shreg);
              ackv_q   <= ack_val;
              sda_oe_r <= pull_for(ack_val);
            end else begin
              state <= ST_WSTOP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            sda_oe_r <= 1'b0;
            state    <= (rw_q && !ackv_q) ? ST_LOAD : ST_WSTOP;
          end
        end
        ST_LOAD: begin
          if (!tx_empty) begin
            shreg    <= tx_buf;
            bit_cnt  <= '0;
            sda_oe_r <= pull_for(tx_buf[DATA_W-1]);
            state    <= ST_SHIFT;
          end else if (ev_release) begin
            state <= ST_WSTOP;
          end
        end
        ST_SHIFT: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              sda_oe_r <= 1'b0;
              state    <= ST_MACK;
            end else begin
              shreg    <= {shreg[DATA_W-2:0], 1'b0};
              sda_oe_r <= pull_for(shreg[DATA_W-2]);
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) nack_q <= sda_s;
          else if (scl_fall) state <= nack_q ? ST_WSTOP : ST_LOAD;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe  = sda_oe_r;
  assign scl_oe  = (state == ST_LOAD);
  assign rx_data = rx_q;

  // R5: SDA drive changes only while the sensed clock is low
  assert_sda_moves_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n || !en)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R3: the ninth clock of a matched address carries the programmed level
  assert_ack_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AACK && scl_rise) |-> (sda_oe == ~ackv_q));

  // R4: transmit mode rises together with the empty flag
  assert_xmit_with_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xmit_mode) |-> tx_empty);

  // R9: a held clock is let go only after data arrived or a dummy read outside transmit mode
  assert_release_cause_R9: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $fell(scl_oe) |-> $past(!tx_empty || (rx_rd && !xmit_mode)));

endmodule

// File: tb/sim_i2c_slave_tx.sv
module sim_i2c_slave_tx;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic ack_val = 1'b0;
  logic tx_wr = 1'b0, rx_rd = 1'b0, xmit_clr = 1'b0, done_clr = 1'b0, empty_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, xmit_mode, tx_empty, tx_done;
  logic [7:0] rx_data;
  wire scl = m_scl & ~scl_oe;
  wire sda = m_sda & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  i2c_slave_tx u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .own_addr(OWN), .ack_val(ack_val),
    .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
    .xmit_clr(xmit_clr), .done_clr(done_clr), .empty_clr(empty_clr),
    .xmit_mode(xmit_mode), .tx_empty(tx_empty), .tx_done(tx_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    int guard = 0;
    m_scl = 1'b1;
    while (scl !== 1'b1 && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 4000) chk("stretch timeout", 0, 1);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; cyc(Q); scl_up(); cyc(Q);
    m_sda = 1'b0; cyc(Q); m_scl = 1'b0; cyc(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; cyc(Q); scl_up(); cyc(Q); m_sda = 1'b1; cyc(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; cyc(Q); scl_up(); cyc(2 * Q); m_scl = 1'b0; cyc(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; cyc(Q); scl_up(); cyc(Q); b = sda; cyc(Q); m_scl = 1'b0; cyc(Q);
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic get_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0; cyc(1);
  endtask

  task automatic host_write(input logic [7:0] v);
    @(negedge clk); tx_data = v; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0; cyc(1);
  endtask

  task automatic t_reset();
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 flags", {xmit_mode, tx_empty, tx_done}, 0);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start(); put_byte({7'h21, 1'b1}); get_bit(a);
    chk("R2 mismatch no ack", a, 1);
    chk("R2 mismatch flags", {xmit_mode, tx_empty, tx_done}, 0);
    bus_stop();
  endtask

  task automatic t_no_start();
    logic a;
    m_scl = 1'b0; cyc(Q);
    put_byte({OWN, 1'b1}); get_bit(a);
    chk("R2 no START no ack", a, 1);
    chk("R2 no START flags", {xmit_mode, tx_empty}, 0);
    bus_stop();
  endtask

  task automatic t_write_ack();
    logic a;
    bus_start(); put_byte({OWN, 1'b0}); get_bit(a);
    chk("R3 ack low", a, 0);
    chk("R4 write keeps xmit_mode 0", xmit_mode, 0);
    chk("R4 rx_data write", rx_data, {OWN, 1'b0});
    bus_stop();
    ack_val = 1'b1;
    bus_start(); put_byte({OWN, 1'b0}); get_bit(a);
    chk("R3 ack_val=1 leaves SDA high", a, 1);
    bus_stop();
    ack_val = 1'b0;
  endtask

  task automatic t_burst();
    logic a;
    logic [7:0] v;
    bus_start(); put_byte({OWN, 1'b1}); get_bit(a);
    chk("R3 read ack", a, 0);
    chk("R4 xmit_mode set", xmit_mode, 1);
    chk("R4 tx_empty set", tx_empty, 1);
    chk("R4 rx_data read", rx_data, {OWN, 1'b1});
    m_scl = 1'b1; cyc(30);
    chk("R8 stretch while empty", scl, 0);
    host_write(8'hA5);
    cyc(3);
    chk("R6 load sets empty", tx_empty, 1);
    host_write(8'h3C);
    chk("R6 write clears empty", tx_empty, 0);
    get_byte(v);
    chk("R5 first byte", v, 8'hA5);
    put_bit(1'b0);
    chk("R7 no end while byte queued", tx_done, 0);
    get_byte(v);
    chk("R6 R5 second byte back to back", v, 8'h3C);
    put_bit(1'b0);
    chk("R7 end flag", tx_done, 1);
    m_scl = 1'b1; cyc(30);
    chk("R8 stretch after last", scl, 0);
    strobe(done_clr);
    chk("R7 end cleared", tx_done, 0);
    strobe(xmit_clr);
    cyc(30);
    chk("R9 still held after xmit_clr", scl, 0);
    chk("R9 xmit_mode cleared", xmit_mode, 0);
    strobe(rx_rd);
    cyc(10);
    chk("R9 released after dummy read", scl, 1);
    chk("R9 empty kept", tx_empty, 1);
    strobe(empty_clr);
    chk("R9 empty cleared", tx_empty, 0);
    m_scl = 1'b0; cyc(Q);
    bus_stop();
    chk("R9 bus idle sda", sda, 1);
  endtask

  task automatic t_master_nack();
    logic a;
    logic [7:0] v;
    bus_start(); put_byte({OWN, 1'b1}); get_bit(a);
    chk("R3 ack nack-case", a, 0);
    host_write(8'hC3);
    get_byte(v);
    chk("R5 byte before nack", v, 8'hC3);
    put_bit(1'b1);
    chk("R7 end on last byte", tx_done, 1);
    m_scl = 1'b1; cyc(30);
    chk("R10 no stretch after nack", scl, 1);
    chk("R10 sda released", sda, 1);
    m_scl = 1'b0; cyc(Q);
    put_bit(1'b0);
    chk("R10 ignores clocks before STOP", sda_oe, 0);
    bus_stop();
    strobe(done_clr); strobe(xmit_clr); strobe(empty_clr);
    chk("R10 flags cleaned", {xmit_mode, tx_empty, tx_done}, 0);
  endtask

  bit finished = 0;

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    en = 1'b1;
    cyc(5);
    t_mismatch();
    t_no_start();
    t_write_ack();
    t_burst();
    t_master_nack();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule